// File: doc/BRIEF.md
# Memory-Mapped Terminal Controller

This block connects a character terminal, a keyboard on the receive side and a display on the transmit side, to a single-cycle word-wide processor load/store bus. Software sees four aligned 32-bit words inside a 16-byte window. Each direction has one status/control word and one data word. Software can poll a ready flag in a status word, or it can set an enable bit and wait for the level-sensitive interrupt line.

On the device side, a received character is delivered as a byte with a one-cycle valid strobe. An outgoing character is presented as a byte with a one-cycle start strobe. The display side answers with a one-cycle done pulse when it can take the next character. The ready flags change as a side effect of bus accesses to the data words: reading the receive data word and writing the transmit data word both drop the ready flag of that direction. Bus reads are combinational from the register state and have their side effects at the clock edge that ends the access.

Top module: `mmio_term_ctrl`

## Requirements
- R1: After reset the receive status word (offset 0x0) reads 0x0, the transmit status word (offset 0x8) reads 0x1, the transmit data word (offset 0xC) reads 0x0, and `irq` is low.
- R2: The block answers only to word-aligned addresses 0xFFFF0000, 0xFFFF0004, 0xFFFF0008 and 0xFFFF000C. A read of any other address returns 0, and a write to any other address changes no state.
- R3: A `rx_valid` pulse stores `rx_byte` and sets receive ready (status bit 0). A read of the receive data word (offset 0x4) returns the stored byte in bits 7:0, with bits 31:8 at zero.
- R4: A read of the receive data word clears receive ready. If a new character arrives in the same cycle, ready stays 1 and the new byte is stored.
- R5: A character that arrives while receive ready is 1 replaces the stored byte and sets the sticky overrun flag in receive status bit 2. A read of the receive status word returns the flag and then clears it.
- R6: The interrupt-enable flag is bit 1 of each status word and is written from bus bit 1. Bus writes to the status words leave the ready flags unchanged.
- R7: A write to the transmit data word (offset 0xC) while transmit ready is 1 drives `tx_byte` with bus bits 7:0. It raises `tx_start` for exactly one cycle, the cycle after the write, and clears transmit ready.
- R8: A write to the transmit data word while transmit ready is 0 is ignored. No strobe is produced and `tx_byte` keeps its value.
- R9: A `tx_done` pulse while transmit ready is 0 sets transmit ready. A `tx_done` pulse while ready is already 1 has no effect.
- R10: `irq` is high exactly when (receive ready and receive enable) or (transmit ready and transmit enable) holds. It stays high until that condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid during a load cycle |
| rx_valid | input | 1 | One-cycle strobe: new keyboard character |
| rx_byte | input | 8 | Keyboard character |
| tx_start | output | 1 | One-cycle strobe: send `tx_byte` |
| tx_byte | output | 8 | Character for the display |
| tx_done | input | 1 | One-cycle pulse: display finished the character |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that every input is a clean synchronous signal. They also assume that `tx_done` is pulsed only after a `tx_start`, and that `rx_valid` and `tx_done` are single-cycle strobes. The stimulus drives all inputs one time unit after a rising edge and holds each bus access and each strobe for exactly one cycle. It raises `tx_done` only while a character is outstanding, except for the single extra pulse that checks R9. That pulse still comes as a lone one-cycle strobe.

// File: rtl/term_pkg.sv
package term_pkg;

  // Register slots inside the window, selected by address bits [3:2].
  typedef enum logic [1:0] {
    SLOT_RX_STAT = 2'd0,
    SLOT_RX_CHAR = 2'd1,
    SLOT_TX_STAT = 2'd2,
    SLOT_TX_CHAR = 2'd3
  } term_slot_e;

  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_BYTES = 4;

  // Status word bit positions.
  localparam int unsigned BIT_RDY = 0;
  localparam int unsigned BIT_IE  = 1;
  localparam int unsigned BIT_OVR = 2;

endpackage

// File: rtl/term_bus_dec.sv
module term_bus_dec
  import term_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic                 sel,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_SLOTS-1:0] rd_hit,
  output logic [NUM_SLOTS-1:0] wr_hit
);

  localparam int unsigned IDX_LSB = $clog2(SLOT_BYTES);
  localparam int unsigned WIN_LSB = $clog2(NUM_SLOTS * SLOT_BYTES);

  logic in_window;
  logic aligned;
  logic [WIN_LSB-IDX_LSB-1:0] idx;

  assign in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign aligned   = (addr[IDX_LSB-1:0] == '0);
  assign idx       = addr[WIN_LSB-1:IDX_LSB];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic slot_match;
    assign slot_match = sel && in_window && aligned && (idx == g[WIN_LSB-IDX_LSB-1:0]);
    assign rd_hit[g]  = slot_match && !we;
    assign wr_hit[g]  = slot_match && we;
  end

endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              rd_char,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic              wr_ie,
  output logic              ready,
  output logic              ie,
  output logic              ovr,
  output logic [CHAR_W-1:0] char_q
);

  logic              ready_d;
  logic              ie_d;
  logic              ovr_d;
  logic [CHAR_W-1:0] char_d;
  logic              char_en;

  always_comb begin
    ready_d = ready;
    ie_d    = ie;
    ovr_d   = ovr;
    char_en = rx_valid;
    char_d  = rx_byte;

    if (rd_char) begin
      ready_d = 1'b0;
    end
    if (rd_stat) begin
      ovr_d = 1'b0;
    end
    if (rx_valid) begin
      ready_d = 1'b1;
      // Unread character lost unless it is being read in this very cycle.
      if (ready && !rd_char) begin
        ovr_d = 1'b1;
      end
    end
    if (wr_stat) begin
      ie_d = wr_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      ie    <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      ready <= ready_d;
      ie    <= ie_d;
      ovr   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
    end else if (char_en) begin
      char_q <= char_d;
    end
  end

endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_char,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              wr_stat,
  input  logic              wr_ie,
  input  logic              tx_done,
  output logic              ready,
  output logic              ie,
  output logic              tx_start,
  output logic [CHAR_W-1:0] tx_byte
);

  logic ready_d;
  logic ie_d;
  logic start_d;
  logic accept;

  // A character is taken only while the display side is idle.
  assign accept = wr_char && ready;

  always_comb begin
    ready_d = ready;
    ie_d    = ie;
    start_d = 1'b0;
    if (accept) begin
      ready_d = 1'b0;
      start_d = 1'b1;
    end else if (tx_done && !ready) begin
      ready_d = 1'b1;
    end
    if (wr_stat) begin
      ie_d = wr_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b1;
      ie       <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      ready    <= ready_d;
      ie       <= ie_d;
      tx_start <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
    end else if (accept) begin
      tx_byte <= wr_byte;
    end
  end

endmodule

// File: rtl/mmio_term_ctrl.sv
module mmio_term_ctrl
  import term_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  output logic              tx_start,
  output logic [CHAR_W-1:0] tx_byte,
  input  logic              tx_done,
  output logic              irq
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_SLOTS-1:0] rd_hit;
  logic [NUM_SLOTS-1:0] wr_hit;

  term_bus_dec #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .sel    (bus_sel),
    .we     (bus_we),
    .addr   (bus_addr),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  logic              rx_rdy_q;
  logic              rx_ie_q;
  logic              rx_ovr_q;
  logic [CHAR_W-1:0] rx_char_q;

  term_rx_chan #(
    .CHAR_W (CHAR_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rd_char  (rd_hit[SLOT_RX_CHAR]),
    .rd_stat  (rd_hit[SLOT_RX_STAT]),
    .wr_stat  (wr_hit[SLOT_RX_STAT]),
    .wr_ie    (bus_wdata[BIT_IE]),
    .ready    (rx_rdy_q),
    .ie       (rx_ie_q),
    .ovr      (rx_ovr_q),
    .char_q   (rx_char_q)
  );

  logic tx_rdy_q;
  logic tx_ie_q;

  term_tx_chan #(
    .CHAR_W (CHAR_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_char  (wr_hit[SLOT_TX_CHAR]),
    .wr_byte  (bus_wdata[CHAR_W-1:0]),
    .wr_stat  (wr_hit[SLOT_TX_STAT]),
    .wr_ie    (bus_wdata[BIT_IE]),
    .tx_done  (tx_done),
    .ready    (tx_rdy_q),
    .ie       (tx_ie_q),
    .tx_start (tx_start),
    .tx_byte  (tx_byte)
  );

  // Store data above the character and enable bits is dropped.
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CHAR_W];

  always_comb begin
    bus_rdata = '0;
    if (rd_hit[SLOT_RX_STAT]) begin
      bus_rdata[BIT_RDY] = rx_rdy_q;
      bus_rdata[BIT_IE]  = rx_ie_q;
      bus_rdata[BIT_OVR] = rx_ovr_q;
    end
    if (rd_hit[SLOT_RX_CHAR]) begin
      bus_rdata[CHAR_W-1:0] = rx_char_q;
    end
    if (rd_hit[SLOT_TX_STAT]) begin
      bus_rdata[BIT_RDY] = tx_rdy_q;
      bus_rdata[BIT_IE]  = tx_ie_q;
    end
  end

  assign irq = (rx_rdy_q && rx_ie_q) || (tx_rdy_q && tx_ie_q);

endmodule

// File: rtl/term_ctrl_chk.sv
module term_ctrl_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_valid,
  input logic              tx_start,
  input logic              tx_done,
  input logic              rx_rdy_q,
  input logic              rx_ie_q,
  input logic              tx_rdy_q,
  input logic              tx_ie_q,
  input logic              irq
);

  logic ld_rx_char;
  logic st_rx_stat;
  logic st_tx_char;

  assign ld_rx_char = bus_sel && !bus_we && (bus_addr == BASE_ADDR + ADDR_W'(4));
  assign st_rx_stat = bus_sel &&  bus_we && (bus_addr == BASE_ADDR);
  assign st_tx_char = bus_sel &&  bus_we && (bus_addr == BASE_ADDR + ADDR_W'(12));

  assert_rx_arrival_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |=> rx_rdy_q);

  assert_rx_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_rx_char && !rx_valid) |=> !rx_rdy_q);

  assert_ready_readonly_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_rx_stat && !rx_valid && !ld_rx_char) |=> (rx_rdy_q == $past(rx_rdy_q)));

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_start |=> !tx_start);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_start |-> !tx_rdy_q);

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_tx_char && !tx_rdy_q) |=> !tx_start);

  assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_done && !st_tx_char) |=> tx_rdy_q);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rx_ie_q && !tx_ie_q) |-> !irq);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (rx_rdy_q || tx_rdy_q));

endmodule

bind mmio_term_ctrl term_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_term_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .rx_valid   (rx_valid),
  .tx_start   (tx_start),
  .tx_done    (tx_done),
  .rx_rdy_q   (rx_rdy_q),
  .rx_ie_q    (rx_ie_q),
  .tx_rdy_q   (tx_rdy_q),
  .tx_ie_q    (tx_ie_q),
  .irq        (irq)
);

// File: tb/tb_mmio_term_ctrl.sv
module tb_mmio_term_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        tx_start;
  logic [7:0]  tx_byte;
  logic        tx_done;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_rd_q[$];
  string       exp_rd_tag[$];
  logic [7:0]  exp_tx_q[$];

  mmio_term_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .tx_start  (tx_start),
    .tx_byte   (tx_byte),
    .tx_done   (tx_done),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares load data and transmit strobes against the queues.
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      if (exp_rd_q.size() == 0) begin
        check(bus_rdata, 32'hDEAD_BEEF, "R2 unexpected load");
      end else begin
        check(bus_rdata, exp_rd_q.pop_front(), exp_rd_tag.pop_front());
      end
    end
    if (rst_n && tx_start) begin
      if (exp_tx_q.size() == 0) begin
        check({24'h0, tx_byte}, 32'hFFFF_FFFF, "R8 strobe not expected");
      end else begin
        check({24'h0, tx_byte}, {24'h0, exp_tx_q.pop_front()}, "R7 tx_byte");
      end
    end
  end

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    exp_rd_q.push_back(exp);
    exp_rd_tag.push_back(req);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic read_with_arrival(input logic [7:0] b, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    exp_rd_q.push_back(exp);
    exp_rd_tag.push_back(req);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = BASE + 32'h4;
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    bus_sel = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] b, input bit accepted);
    if (accepted) exp_tx_q.push_back(b);
    bus_write(BASE + 32'hC, {24'hABCDEF, b});
  endtask

  task automatic done_pulse();
    @(posedge clk); #1;
    tx_done = 1'b1;
    @(posedge clk); #1;
    tx_done = 1'b0;
  endtask

  task automatic check_irq(input logic exp, input string req);
    @(negedge clk);
    check({31'h0, irq}, {31'h0, exp}, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_byte = '0; tx_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    bus_read(BASE + 32'h0, 32'h0, "R1 rx status");
    bus_read(BASE + 32'h8, 32'h1, "R1 tx status");
    bus_read(BASE + 32'hC, 32'h0, "R1 tx data");
    check_irq(1'b0, "R1 irq");

    // R3 / R4: simple arrival and consumption
    rx_send(8'h5A);
    bus_read(BASE + 32'h0, 32'h1, "R3 rx ready");
    bus_read(BASE + 32'h4, 32'h5A, "R3 rx char");
    bus_read(BASE + 32'h0, 32'h0, "R4 ready cleared");

    // R5: overrun
    rx_send(8'h11);
    rx_send(8'h22);
    bus_read(BASE + 32'h0, 32'h5, "R5 overrun flagged");
    bus_read(BASE + 32'h0, 32'h1, "R5 overrun cleared");
    bus_read(BASE + 32'h4, 32'h22, "R5 overwritten char");

    // R4: read and arrival in the same cycle
    rx_send(8'h33);
    read_with_arrival(8'h44, 32'h33, "R4 same-cycle read");
    bus_read(BASE + 32'h0, 32'h1, "R4 ready kept no overrun");
    bus_read(BASE + 32'h4, 32'h44, "R4 new char");
    bus_read(BASE + 32'h0, 32'h0, "R4 ready cleared again");

    // R6: enable writable, ready read-only
    bus_write(BASE + 32'h0, 32'hFFFF_FFFF);
    bus_read(BASE + 32'h0, 32'h2, "R6 rx ie set ready untouched");
    check_irq(1'b0, "R10 rx enabled but not ready");
    rx_send(8'h77);
    check_irq(1'b1, "R10 rx irq");
    check_irq(1'b1, "R10 rx irq level held");
    bus_read(BASE + 32'h4, 32'h77, "R3 char with ie");
    check_irq(1'b0, "R10 rx irq dropped");
    bus_write(BASE + 32'h0, 32'h0);
    bus_read(BASE + 32'h0, 32'h0, "R6 rx ie cleared");

    // R2: decoding
    bus_write(BASE + 32'h10, 32'h2);
    bus_write(32'h0000_0008, 32'h2);
    bus_write(BASE + 32'h9, 32'h2);
    bus_read(BASE + 32'h8, 32'h1, "R2 stray writes ignored");
    bus_read(BASE + 32'h10, 32'h0, "R2 past window");
    bus_read(32'h0000_0000, 32'h0, "R2 low address");
    rx_send(8'h66);
    bus_read(BASE + 32'h5, 32'h0, "R2 unaligned read");
    bus_read(BASE + 32'h0, 32'h1, "R2 unaligned read no side effect");
    bus_read(BASE + 32'h4, 32'h66, "R3 char after stray read");

    // R7 / R8 / R9: transmit
    tx_write(8'h41, 1'b1);
    bus_read(BASE + 32'h8, 32'h0, "R7 tx busy");
    tx_write(8'h42, 1'b0);
    check({24'h0, tx_byte}, 32'h41, "R8 tx_byte kept");
    bus_read(BASE + 32'h8, 32'h0, "R8 still busy");
    bus_write(BASE + 32'h8, 32'h1);
    bus_read(BASE + 32'h8, 32'h0, "R6 tx ready not writable");
    done_pulse();
    bus_read(BASE + 32'h8, 32'h1, "R9 ready back");
    done_pulse();
    bus_read(BASE + 32'h8, 32'h1, "R9 extra done no effect");

    // R10: transmit interrupt
    bus_write(BASE + 32'h8, 32'h2);
    check_irq(1'b1, "R10 tx irq");
    tx_write(8'h43, 1'b1);
    check_irq(1'b0, "R10 tx irq drops while busy");
    done_pulse();
    check_irq(1'b1, "R10 tx irq returns");
    bus_write(BASE + 32'h8, 32'h0);
    check_irq(1'b0, "R10 tx irq masked");

    repeat (3) @(posedge clk);
    check(exp_rd_q.size(), 0, "R2 loads outstanding");
    check(exp_tx_q.size(), 0, "R7 missing strobe");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule